// File: doc/BRIEF.md
# Per-Area External Bus Access Sequencer

This block turns CPU-side access requests into timed cycles on an external memory bus. The external address space is split into eight areas. The top three bits of the request address pick the area. Each area has two settings, held in two 8-bit configuration registers: whether the area is 8 or 16 bits wide, and whether each bus cycle lasts two or three bus states. Software reads and writes both registers through a small register port. A 16-bit request to an 8-bit area is split into two byte cycles. The block drives the address, write data and read/write strobes, samples read data at the end of the cycle, and then pulses a done flag with the result.

Requests aimed at on-chip memory or internal registers ignore both settings. They always run as a single 16-bit access of fixed length, signalled by an internal enable instead of the external strobes. When the single-chip input is high, every request is handled this way.

The request port follows a valid/ready rule. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The requester must hold the valid flag and all request fields steady until that edge. `req_ready` is high only when no access is in progress and software standby is off. The response cannot be held back: `rsp_done` is a single-clock pulse, and `rsp_rdata` is valid in that clock for reads.

Top module: `area_bus_seq`

## Requirements
- R1: The area of a request is `req_addr[23:21]`. Bit n of the width register (select 0) sets area n: 1 means the area is 8 bits wide, 0 means it is 16 bits wide.
- R2: Bit n of the state register (select 1) sets area n: 0 gives two states per bus cycle, 1 gives three. Each state lasts one clock. `rsp_done` is high for exactly one clock, the clock after the edge that ends the final state. If the request was accepted at edge E, a single cycle of S states raises `rsp_done` after edge E+S.
- R3: A low `rst_n` sets both registers to 8'hFF. A clock edge with `hw_stby` high also sets both to 8'hFF and stops any access in progress.
- R4: While `sw_stby` is high, both registers keep their values and `req_ready` is low, so no request is accepted and no strobe or internal enable is driven.
- R5: A write (`cfg_wr`) stores `cfg_wdata` into the register chosen by `cfg_sel` (0 = width, 1 = states). `cfg_rdata` shows the chosen register in the same clock.
- R6: An internal request (`req_internal` = 1) ignores both registers. It takes 2 states as one 16-bit access with `int_en` high for the whole access. `ext_rd` and `ext_wr` stay low. Read data comes from `int_rdata`.
- R7: While `single_chip` is high, every request is treated as internal, whatever `req_internal` and the registers hold.
- R8: A 16-bit request (`req_wide` = 1) to an 8-bit area runs two byte cycles, each with that area's state count. The first cycle uses the even address and carries the upper byte. The second uses the odd address and carries the lower byte. Both cycles use data lane [15:8]. The read result is {first byte, second byte}.
- R9: `ext_rd` (reads) or `ext_wr` (writes) is high from the second state to the last state of every external cycle, and low in the first state. Read data on `ext_din` is captured at the edge that ends the last state.
- R10: `req_ready` is low from the acceptance edge until the access completes. A new request can be accepted at the edge that raises `rsp_done`.
- R11: For a byte request to a 16-bit area, `req_addr[0]` = 0 uses lane [15:8] and 1 uses lane [7:0]. For a byte request to an 8-bit area, lane [15:8] is used. A byte result is returned in `rsp_rdata[7:0]` with [15:8] zero. Byte write data comes from `req_wdata[7:0]`. A 16-bit request to a 16-bit area uses the even address and both lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby: reinitialises registers, aborts access |
| sw_stby | input | 1 | Software standby: holds registers, blocks requests |
| single_chip | input | 1 | Treat every request as internal |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 width, 1 states |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Selected register contents |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for 16-bit access, 0 for byte |
| req_internal | input | 1 | Target is on-chip memory or registers |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| bus_addr | output | 24 | Address of the current cycle (external or internal) |
| bus_wdata | output | 16 | Write data of the current cycle |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_din | input | 16 | External read data |
| int_en | output | 1 | Internal access enable |
| int_we | output | 1 | Internal write enable |
| int_rdata | input | 16 | Internal read data |

## Verification
The hardest case to reach is a 16-bit request to a narrow, three-state area. Six clocks of state must line up: each byte must be captured at the edge that ends its own cycle, and the second cycle must start with its strobe low again. The bench's memory model returns a marker value whenever `ext_rd` is low. A capture in the wrong state therefore shows up in the assembled result, and the bench also counts strobe clocks against states minus cycles. Software standby is reached by raising `sw_stby` while a request is already presented. The bench then watches that nothing starts and that the registers read back unchanged.

// File: rtl/area_bus_pkg.sv
package area_bus_pkg;
  localparam int NUM_AREAS = 8;
  localparam int AREA_BITS = $clog2(NUM_AREAS);
  localparam int DATA_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int STATE_W   = 2;

  typedef struct packed {
    logic [STATE_W-1:0] states;
    logic               byte_area;
    logic               two_cyc;
    logic               internal;
  } acc_plan_t;
endpackage

// File: rtl/area_cfg_regs.sv
module area_cfg_regs
  import area_bus_pkg::*;
#(
  parameter int N = NUM_AREAS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_stby,
  input  logic         sw_stby,
  input  logic         cfg_wr,
  input  logic         cfg_sel,
  input  logic [N-1:0] cfg_wdata,
  output logic [N-1:0] cfg_rdata,
  output logic [N-1:0] width_o,
  output logic [N-1:0] states_o
);
  logic [N-1:0] width_q, states_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '1;
      states_q <= '1;
    end else if (hw_stby) begin
      width_q  <= '1;
      states_q <= '1;
    end else if (cfg_wr) begin
      if (cfg_sel) states_q <= cfg_wdata;
      else         width_q  <= cfg_wdata;
    end
  end

  assign cfg_rdata = cfg_sel ? states_q : width_q;
  assign width_o   = width_q;
  assign states_o  = states_q;

  // R3: hardware standby reinitialises both registers
  a_r3_hwstby_init: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (width_q == '1 && states_q == '1));

  // R4: software standby leaves register contents alone
  a_r4_swstby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !cfg_wr && !hw_stby) |=> ($stable(width_q) && $stable(states_q)));
endmodule

// File: rtl/area_access_plan.sv
module area_access_plan
  import area_bus_pkg::*;
#(
  parameter int N          = NUM_AREAS,
  parameter int FIX_STATES = 2
) (
  input  logic [AREA_BITS-1:0] area,
  input  logic                 req_internal,
  input  logic                 single_chip,
  input  logic                 req_wide,
  input  logic [N-1:0]         width,
  input  logic [N-1:0]         states,
  output acc_plan_t            plan
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_area
    assign hit[g] = (area == AREA_BITS'(g));
  end

  logic is_int, narrow, slow;
  assign is_int = req_internal | single_chip;
  assign narrow = |(hit & width);
  assign slow   = |(hit & states);

  always_comb begin
    plan.internal  = is_int;
    plan.byte_area = !is_int && narrow;
    plan.two_cyc   = !is_int && narrow && req_wide;
    plan.states    = is_int ? STATE_W'(FIX_STATES)
                            : (slow ? STATE_W'(3) : STATE_W'(2));
  end
endmodule

// File: rtl/area_cycle_fsm.sv
module area_cycle_fsm
  import area_bus_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  acc_plan_t         plan,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              ext_rd,
  output logic              ext_wr,
  input  logic [DATA_W-1:0] ext_din,
  output logic              int_en,
  output logic              int_we,
  input  logic [DATA_W-1:0] int_rdata
);
  logic               busy, second, two_cyc, byte_area, is_int, wr, wide, done_q;
  logic [STATE_W-1:0] tcnt, lim;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q, rd_result, src, dout;
  logic [BYTE_W-1:0]  hi_q, byte_in;
  logic               accept, last_state, final_cyc, strobe_ph;
  logic [ADDR_W-1:0]  base, cyc_addr;

  assign req_ready  = !busy && !sw_stby;
  assign accept     = req_valid && req_ready;
  assign last_state = (tcnt == lim);
  assign final_cyc  = !two_cyc || second;

  assign byte_in = ext_din[DATA_W-1 -: BYTE_W];
  assign src     = is_int ? int_rdata : ext_din;

  always_comb begin
    if (byte_area)
      rd_result = two_cyc ? {hi_q, byte_in} : {{BYTE_W{1'b0}}, byte_in};
    else if (wide)
      rd_result = src;
    else if (addr_q[0])
      rd_result = {{BYTE_W{1'b0}}, src[BYTE_W-1:0]};
    else
      rd_result = {{BYTE_W{1'b0}}, src[DATA_W-1 -: BYTE_W]};
  end

  assign base     = wide ? {addr_q[ADDR_W-1:1], 1'b0} : addr_q;
  assign cyc_addr = {base[ADDR_W-1:1], two_cyc ? second : base[0]};

  always_comb begin
    if (byte_area) begin
      if (two_cyc && !second) dout = {wdata_q[DATA_W-1 -: BYTE_W], {BYTE_W{1'b0}}};
      else                    dout = {wdata_q[BYTE_W-1:0], {BYTE_W{1'b0}}};
    end else if (wide) begin
      dout = wdata_q;
    end else if (addr_q[0]) begin
      dout = {{BYTE_W{1'b0}}, wdata_q[BYTE_W-1:0]};
    end else begin
      dout = {wdata_q[BYTE_W-1:0], {BYTE_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; second <= 1'b0; two_cyc <= 1'b0; byte_area <= 1'b0;
      is_int <= 1'b0; wr <= 1'b0; wide <= 1'b0; done_q <= 1'b0;
      tcnt <= '0; lim <= '0; addr_q <= '0; wdata_q <= '0;
      rdata_q <= '0; hi_q <= '0;
    end else if (hw_stby) begin
      busy <= 1'b0; second <= 1'b0; done_q <= 1'b0; tcnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        tcnt      <= STATE_W'(1);
        lim       <= plan.states;
        second    <= 1'b0;
        two_cyc   <= plan.two_cyc;
        byte_area <= plan.byte_area;
        is_int    <= plan.internal;
        wr        <= req_write;
        wide      <= req_wide;
        addr_q    <= req_addr;
        wdata_q   <= req_wdata;
      end else if (busy) begin
        if (last_state) begin
          if (!final_cyc) begin
            second <= 1'b1;
            tcnt   <= STATE_W'(1);
            hi_q   <= byte_in;
          end else begin
            busy    <= 1'b0;
            done_q  <= 1'b1;
            rdata_q <= wr ? '0 : rd_result;
          end
        end else begin
          tcnt <= tcnt + STATE_W'(1);
        end
      end
    end
  end

  assign strobe_ph = busy && (tcnt != STATE_W'(1));
  assign ext_rd    = strobe_ph && !is_int && !wr;
  assign ext_wr    = strobe_ph && !is_int && wr;
  assign int_en    = busy && is_int;
  assign int_we    = busy && is_int && wr;
  assign bus_addr  = busy ? cyc_addr : '0;
  assign bus_wdata = (busy && wr) ? (is_int ? wdata_q : dout) : '0;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  // R9: read and write strobes never overlap
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));
  // R9: the first state of an access carries no strobe
  a_r9_first_state_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!ext_rd && !ext_wr));
  // R2: done lasts one clock
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R6: internal accesses keep the external strobes low
  a_r6_int_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    int_en |-> (!ext_rd && !ext_wr));
  // R10: an idle port drives no access
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ext_rd && !ext_wr && !int_en));
  // R4: software standby accepts nothing
  a_r4_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stby |-> !req_ready);
endmodule

// File: rtl/area_bus_seq.sv
module area_bus_seq
  import area_bus_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int FIX_STATES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              single_chip,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic              req_internal,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  output logic              ext_rd,
  output logic              ext_wr,
  input  logic [15:0]       ext_din,
  output logic              int_en,
  output logic              int_we,
  input  logic [15:0]       int_rdata
);
  logic [NUM_AREAS-1:0] width_v, states_v;
  acc_plan_t            plan;

  area_cfg_regs #(.N(NUM_AREAS)) i_regs (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .width_o(width_v), .states_o(states_v)
  );

  area_access_plan #(.N(NUM_AREAS), .FIX_STATES(FIX_STATES)) i_plan (
    .area(req_addr[ADDR_W-1 -: AREA_BITS]), .req_internal(req_internal),
    .single_chip(single_chip), .req_wide(req_wide),
    .width(width_v), .states(states_v), .plan(plan)
  );

  area_cycle_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .plan(plan), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_din(ext_din), .int_en(int_en), .int_we(int_we),
    .int_rdata(int_rdata)
  );
endmodule

// File: tb/test_area_bus_seq.sv
module test_area_bus_seq;
  logic clk = 1'b0, rst_n = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0, single_chip = 1'b0;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_wide = 1'b0, req_internal = 1'b0;
  logic [23:0] req_addr = '0, bus_addr;
  logic [15:0] req_wdata = '0, rsp_rdata, bus_wdata, ext_din, int_rdata;
  logic rsp_done, ext_rd, ext_wr, int_en, int_we;

  area_bus_seq i_area_bus_seq (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .single_chip(single_chip), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_wide(req_wide),
    .req_internal(req_internal), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_din(ext_din),
    .int_en(int_en), .int_we(int_we), .int_rdata(int_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] hi_b(input logic [23:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] lo_b(input logic [23:0] a);
    return a[7:0] ^ 8'hC3;
  endfunction

  assign ext_din   = ext_rd ? {hi_b(bus_addr), lo_b(bus_addr)} : 16'hDEAD;
  assign int_rdata = int_en ? {bus_addr[7:0], ~bus_addr[7:0]} : 16'h0000;

  int cyc = 0, n_chk = 0, n_fail = 0, accept_cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] m_width = 8'hFF, m_states = 8'hFF;
  logic [23:0] first_wa, last_wa;
  logic [7:0]  first_wd, last_wd;

  typedef struct { logic [15:0] data; bit is_rd; int lat; string tag; } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard at each completion
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (sb.size() == 0) check(1'b0, "R2 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc - accept_cyc == e.lat, {e.tag, " latency"}, cyc - accept_cyc, e.lat);
        if (e.is_rd) check(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
      end
    end
  end

  task automatic cfg_write(input bit sel, input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel) m_states = v; else m_width = v;
  endtask

  task automatic cfg_check(input bit sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_sel = sel;
    #1 check(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic run_req(input logic [2:0] area, input logic [20:0] low, input bit wide,
                         input bit wr, input bit intl, input logic [15:0] wd, input string tag);
    logic [23:0] a, ae;
    logic [15:0] full, ed;
    bit eint, ebyte, etwo;
    int est, ncyc, total, nstb, nint;
    exp_t e;
    a = {area, low};
    ae = wide ? {a[23:1], 1'b0} : a;
    eint = intl || single_chip;
    ebyte = !eint && m_width[area];
    etwo = ebyte && wide;
    est = eint ? 2 : (m_states[area] ? 3 : 2);
    ncyc = etwo ? 2 : 1;
    total = est * ncyc;
    if (eint) begin
      full = {ae[7:0], ~ae[7:0]};
      ed = wide ? full : (a[0] ? {8'h00, full[7:0]} : {8'h00, full[15:8]});
    end else if (ebyte) begin
      ed = etwo ? {hi_b(ae), hi_b(ae | 24'h1)} : {8'h00, hi_b(a)};
    end else begin
      ed = wide ? {hi_b(ae), lo_b(ae)} : (a[0] ? {8'h00, lo_b(a)} : {8'h00, hi_b(a)});
    end
    e.data = ed; e.is_rd = !wr; e.lat = total; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wide = wide; req_write = wr;
    req_internal = intl; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    accept_cyc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, {tag, " R10 busy"}, req_ready, 0);
    nstb = 0; nint = 0;
    while (!rsp_done) begin
      if (ext_rd || ext_wr) begin
        if (nstb == 0) begin first_wa = bus_addr; first_wd = bus_wdata[15:8]; end
        last_wa = bus_addr; last_wd = bus_wdata[15:8];
        nstb++;
      end
      if (int_en) nint++;
      @(negedge clk);
    end
    if (eint) begin
      check(nstb == 0, {tag, " R6 no ext strobe"}, nstb, 0);
      check(nint == 2, {tag, " R6 int_en length"}, nint, 2);
    end else begin
      check(nstb == total - ncyc, {tag, " R9 strobe clocks"}, nstb, total - ncyc);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R3 / R5 reset state
    cfg_check(1'b0, 8'hFF, "R3 width reset");
    cfg_check(1'b1, 8'hFF, "R3 states reset");
    check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    check(!ext_rd && !ext_wr && !int_en, "R9 idle strobes", ext_rd, 0);
    // default: every area narrow and three-state
    run_req(3'd5, 21'h000124, 1'b1, 1'b0, 1'b0, 16'h0, "R8 R2 default wide read");
    // R5 program the registers
    cfg_write(1'b0, 8'hF0);
    cfg_write(1'b1, 8'hCC);
    cfg_check(1'b0, 8'hF0, "R5 width readback");
    cfg_check(1'b1, 8'hCC, "R5 states readback");
    // R1 R2 R11 areas 0..3 wide (16-bit)
    run_req(3'd0, 21'h000040, 1'b1, 1'b0, 1'b0, 16'h0, "R1 R2 area0 wide 2-state");
    run_req(3'd2, 21'h000062, 1'b0, 1'b0, 1'b0, 16'h0, "R11 area2 even byte");
    run_req(3'd2, 21'h000063, 1'b0, 1'b0, 1'b0, 16'h0, "R11 area2 odd byte");
    run_req(3'd3, 21'h000081, 1'b1, 1'b0, 1'b0, 16'h0, "R11 area3 wide unaligned");
    // R8 narrow areas
    run_req(3'd4, 21'h000010, 1'b1, 1'b0, 1'b0, 16'h0, "R8 area4 wide 2-state");
    run_req(3'd4, 21'h000017, 1'b0, 1'b0, 1'b0, 16'h0, "R11 area4 byte");
    run_req(3'd7, 21'h0000A6, 1'b1, 1'b0, 1'b0, 16'h0, "R8 area7 wide 3-state");
    // R6 internal
    run_req(3'd1, 21'h000035, 1'b0, 1'b0, 1'b1, 16'h0, "R6 internal byte");
    run_req(3'd6, 21'h000034, 1'b1, 1'b0, 1'b1, 16'h0, "R6 internal wide");
    // R8 wide write to narrow area: upper byte first at even address
    run_req(3'd6, 21'h000051, 1'b1, 1'b1, 1'b0, 16'hB7E4, "R8 area6 wide write");
    check(first_wa[0] == 1'b0 && first_wd == 8'hB7, "R8 first write byte", first_wd, 8'hB7);
    check(last_wa[0] == 1'b1 && last_wd == 8'hE4, "R8 second write byte", last_wd, 8'hE4);
    // R4 software standby
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h200010; req_wide = 1'b0; req_write = 1'b0; req_internal = 1'b0;
    sw_stby = 1'b1;
    #1 check(req_ready == 1'b0, "R4 ready low in sw standby", req_ready, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!ext_rd && !int_en && !rsp_done, "R4 no access in sw standby", ext_rd, 0);
    end
    req_valid = 1'b0;
    cfg_check(1'b0, 8'hF0, "R4 width kept");
    cfg_check(1'b1, 8'hCC, "R4 states kept");
    @(negedge clk) sw_stby = 1'b0;
    // R3 hardware standby
    @(negedge clk) hw_stby = 1'b1;
    @(negedge clk) hw_stby = 1'b0;
    m_width = 8'hFF; m_states = 8'hFF;
    cfg_check(1'b0, 8'hFF, "R3 width after hw standby");
    cfg_check(1'b1, 8'hFF, "R3 states after hw standby");
    // R7 single-chip mode forces internal path
    cfg_write(1'b0, 8'h00);
    cfg_write(1'b1, 8'h00);
    @(negedge clk) single_chip = 1'b1;
    run_req(3'd3, 21'h000072, 1'b1, 1'b0, 1'b0, 16'h0, "R7 single-chip read");
    @(negedge clk) single_chip = 1'b0;
    run_req(3'd3, 21'h000072, 1'b1, 1'b0, 1'b0, 16'h0, "R7 external after single-chip");
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule